// File: doc/BRIEF.md
# RMII Receive Output Stage

This block is the last stage of a PHY receive path facing the MAC over a reduced media-independent interface. Received bytes come in through a valid/ready stream and wait in a small FIFO. A carrier indication that is not aligned to the clock, plus a false-carrier flag, decide when the combined carrier-sense/data-valid output is raised. The block emits each byte as four 2-bit symbols on the receive data pins, on a 50 MHz reference clock. At 100 Mb/s a new symbol appears every cycle. At 10 Mb/s each symbol is held for ten cycles.

When carrier goes away while bytes are still queued, the carrier-sense/data-valid output does not just fall. It drops on each first symbol of a symbol pair and rises again on each second symbol, until the queue is empty. The MAC uses this to tell that carrier has ended while it still collects the remaining data.

On the input stream, a byte is accepted on any rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low exactly when the FIFO holds its full depth. A byte offered while `in_ready` is low is not stored, and the source must hold it until it is accepted. The FIFO is read only while a frame is being sent.

Top module: `rmii_rx_stage`

## Requirements
- R1: After reset, `crs_dv` is 0, `rxd` is 00 and `in_ready` is 1.
- R2: `carrier_in` passes through a two-flop synchroniser. `crs_dv` goes high on the third rising edge after `carrier_in` rises. On that edge `rxd` is 00 for a normal carrier and 10 for a false carrier.
- R3: In 100 Mb/s mode (`slow_mode`=0), queued bytes appear on `rxd` one symbol per cycle, starting on the edge after `crs_dv` rises. Each byte is sent bits [1:0] first, then [3:2], [5:4] and [7:6].
- R4: In 10 Mb/s mode (`slow_mode`=1), each symbol is held on `rxd` for 10 consecutive cycles. The end-of-carrier and underflow rules act on this symbol pacing.
- R5: If carrier (after the synchroniser) is low at a first symbol of a pair (bits [1:0] or [5:4] of a byte) and data remains, `crs_dv` is 0 on that symbol. It is 1 on the following second symbol ([3:2] or [7:6]). This repeats until every queued symbol has been sent.
- R6: Once the queue is drained after carrier loss, `crs_dv` is 0 and `rxd` is 00 on the next symbol slot. Outside the draining window, `rxd` is 00 whenever `crs_dv` is 0.
- R7: While `false_car` was high when carrier started, `crs_dv` stays 1 and `rxd` carries 10 until the synchronised carrier falls. `crs_dv` is 0 one edge after that. The FIFO is not read during the event.
- R8: If a frame has started and the FIFO is empty at a first symbol while carrier is still present, `crs_dv` goes to 0 on that symbol. It stays 0, with `rxd` 00, until carrier goes away.
- R9: `in_ready` is 0 while the FIFO holds 8 bytes (the default depth). A byte offered while `in_ready` is 0 is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| slow_mode | input | 1 | 1 selects 10 Mb/s symbol pacing, 0 selects 100 Mb/s |
| carrier_in | input | 1 | Receive medium non-idle, not clock-aligned |
| false_car | input | 1 | Marks the current carrier event as false carrier |
| in_valid | input | 1 | Received byte offered |
| in_ready | output | 1 | FIFO can accept a byte |
| in_data | input | 8 | Received byte |
| rxd | output | 2 | Receive symbol to the MAC |
| crs_dv | output | 1 | Combined carrier sense / data valid |

## Verification
A carrier change reaches `crs_dv` on the third rising edge: two synchroniser flops plus the output register. The first symbol follows one edge later. Each later symbol comes one edge apart at 100 Mb/s and ten edges apart at 10 Mb/s. A synchronised carrier loss takes effect at the next first-symbol slot. For a false carrier, a loss clears `crs_dv` one edge after the synchroniser output falls. The bench changes inputs on falling edges and counts rising edges from that point. It samples at the falling edge after the edge where each result is due, so every check lands on a known symbol slot. Each toggle sequence is compared symbol by symbol against a table built from the byte values.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACTIVE,
    ST_DRAIN,
    ST_FALSE,
    ST_ENDED
  } rx_state_e;

  localparam logic [1:0] FALSE_SYM = 2'b10;
  localparam logic [1:0] QUIET_SYM = 2'b00;
endpackage

// File: rtl/rmii_rx_sync.sv
module rmii_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_in};
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/rmii_rx_fifo.sv
module rmii_rx_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_CNT);
  assign rd_data = mem[rp_q];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en) wp_q <= wp_q + 1'b1;
      if (rd_en) rp_q <= rp_q + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_en);

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !rd_en);
endmodule

// File: rtl/rmii_rx_pacer.sv
module rmii_rx_pacer #(
  parameter int SLOW_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_mode,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (run)    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign tick = !slow_mode || (cnt_q == '0);
endmodule

// File: rtl/rmii_rx_stage.sv
module rmii_rx_stage
  import rmii_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int SLOW_DIV   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_mode,
  input  logic              carrier_in,
  input  logic              false_car,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic [1:0]        rxd,
  output logic              crs_dv
);
  localparam int SYMS = DATA_W / 2;
  localparam int PW   = (SYMS > 1) ? $clog2(SYMS) : 1;

  rx_state_e st_q, st_d;
  logic              car_s;
  logic              tick, pace_clr, pace_run;
  logic              fifo_empty, fifo_full, pop, push;
  logic [DATA_W-1:0] fifo_data;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [PW-1:0]     ph_q, ph_d;
  logic              crs_q, crs_d;
  logic [1:0]        rxd_q, rxd_d;
  logic              started_q, started_d;
  logic              avail;
  logic [1:0]        cur_sym;

  rmii_rx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(carrier_in), .d_out(car_s)
  );

  assign push     = in_valid && !fifo_full;
  assign in_ready = !fifo_full;

  rmii_rx_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(push), .wr_data(in_data),
    .rd_en(pop), .rd_data(fifo_data),
    .empty(fifo_empty), .full(fifo_full)
  );

  assign pace_run = (st_q != ST_IDLE);

  rmii_rx_pacer #(.SLOW_DIV(SLOW_DIV)) u_pacer (
    .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode),
    .clr(pace_clr), .run(pace_run), .tick(tick)
  );

  assign avail   = (ph_q != '0) || !fifo_empty;
  assign cur_sym = (ph_q == '0) ? fifo_data[1:0] : sh_q[{ph_q, 1'b0} +: 2];

  always_comb begin
    st_d      = st_q;
    crs_d     = crs_q;
    rxd_d     = rxd_q;
    ph_d      = ph_q;
    sh_d      = sh_q;
    started_d = started_q;
    pop       = 1'b0;
    pace_clr  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        crs_d = 1'b0;
        rxd_d = QUIET_SYM;
        if (car_s) begin
          crs_d     = 1'b1;
          pace_clr  = 1'b1;
          ph_d      = '0;
          started_d = 1'b0;
          if (false_car) begin
            st_d  = ST_FALSE;
            rxd_d = FALSE_SYM;
          end else begin
            st_d  = ST_ACTIVE;
          end
        end
      end
      ST_ACTIVE: begin
        if (tick) begin
          if (!ph_q[0] && !car_s) begin
            crs_d = 1'b0;
            if (avail) begin
              st_d  = ST_DRAIN;
              rxd_d = cur_sym;
              ph_d  = ph_q + 1'b1;
              if (ph_q == '0) begin
                pop  = 1'b1;
                sh_d = fifo_data;
              end
            end else begin
              st_d  = ST_IDLE;
              rxd_d = QUIET_SYM;
            end
          end else if (avail) begin
            crs_d     = 1'b1;
            started_d = 1'b1;
            rxd_d     = cur_sym;
            ph_d      = ph_q + 1'b1;
            if (ph_q == '0) begin
              pop  = 1'b1;
              sh_d = fifo_data;
            end
          end else if (started_q) begin
            st_d  = ST_ENDED;
            crs_d = 1'b0;
            rxd_d = QUIET_SYM;
          end else begin
            rxd_d = QUIET_SYM;
          end
        end
      end
      ST_DRAIN: begin
        if (tick) begin
          if (avail) begin
            crs_d = ph_q[0];
            rxd_d = cur_sym;
            ph_d  = ph_q + 1'b1;
            if (ph_q == '0) begin
              pop  = 1'b1;
              sh_d = fifo_data;
            end
          end else begin
            st_d  = ST_IDLE;
            crs_d = 1'b0;
            rxd_d = QUIET_SYM;
          end
        end
      end
      ST_FALSE: begin
        crs_d = 1'b1;
        rxd_d = FALSE_SYM;
        if (!car_s) begin
          st_d  = ST_IDLE;
          crs_d = 1'b0;
          rxd_d = QUIET_SYM;
        end
      end
      ST_ENDED: begin
        crs_d = 1'b0;
        rxd_d = QUIET_SYM;
        if (!car_s) st_d = ST_IDLE;
      end
      default: begin
        st_d  = ST_IDLE;
        crs_d = 1'b0;
        rxd_d = QUIET_SYM;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      crs_q     <= 1'b0;
      rxd_q     <= QUIET_SYM;
      ph_q      <= '0;
      sh_q      <= '0;
      started_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      crs_q     <= crs_d;
      rxd_q     <= rxd_d;
      ph_q      <= ph_d;
      sh_q      <= sh_d;
      started_q <= started_d;
    end
  end

  assign rxd    = rxd_q;
  assign crs_dv = crs_q;

  // R2
  crs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (car_s && st_q == ST_IDLE) |=> crs_q);

  // R4
  slow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_mode && !tick && (st_q == ST_ACTIVE || st_q == ST_DRAIN)) |=> $stable(rxd_q));

  // R6
  rxd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!crs_q && st_q != ST_DRAIN) |-> (rxd_q == QUIET_SYM));

  // R7
  false_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FALSE) |-> !pop);
endmodule

// File: tb/rmii_rx_stage_bench.sv
module rmii_rx_stage_bench;
  localparam int CLK_NS = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_mode = 1'b0;
  logic       carrier_in = 1'b0;
  logic       false_car = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic [1:0] rxd;
  logic       crs_dv;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS / 2) clk = ~clk;

  rmii_rx_stage u_rmii_rx_stage (
    .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode),
    .carrier_in(carrier_in), .false_car(false_car),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .rxd(rxd), .crs_dv(crs_dv)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic expect_out(input string req, input logic c, input logic [1:0] d);
    check({req, " crs_dv"}, int'(crs_dv), int'(c));
    check({req, " rxd"}, int'(rxd), int'(d));
  endtask

  task automatic push(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    cyc(1);
    in_valid = 1'b0;
  endtask

  task automatic end_carrier();
    carrier_in = 1'b0;
    cyc(5);
    expect_out("R6 idle", 1'b0, 2'b00);
  endtask

  task automatic test_reset();
    expect_out("R1 reset", 1'b0, 2'b00);
    check("R1 in_ready", int'(in_ready), 1);
  endtask

  task automatic test_fast_underflow();
    push(8'h9C);
    carrier_in = 1'b1;
    cyc(2);
    check("R2 not yet", int'(crs_dv), 0);
    cyc(1);
    expect_out("R2 rise", 1'b1, 2'b00);
    cyc(1); expect_out("R3 sym0", 1'b1, 2'b00);
    cyc(1); expect_out("R3 sym1", 1'b1, 2'b11);
    cyc(1); expect_out("R3 sym2", 1'b1, 2'b01);
    cyc(1); expect_out("R3 sym3", 1'b1, 2'b10);
    cyc(1); expect_out("R8 underflow", 1'b0, 2'b00);
    cyc(5); expect_out("R8 stays low", 1'b0, 2'b00);
    end_carrier();
  endtask

  task automatic test_toggle();
    logic       exp_c [9] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    logic [1:0] exp_d [9] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b11, 2'b10, 2'b01, 2'b00, 2'b00};
    push(8'hE4);
    push(8'h1B);
    carrier_in = 1'b1;
    cyc(3);
    expect_out("R2 rise", 1'b1, 2'b00);
    carrier_in = 1'b0;
    for (int i = 0; i < 9; i++) begin
      cyc(1);
      expect_out($sformatf("R5 drain slot %0d", i), exp_c[i], exp_d[i]);
    end
    cyc(3);
    expect_out("R6 drained", 1'b0, 2'b00);
  endtask

  task automatic test_false();
    push(8'h5A);
    false_car  = 1'b1;
    carrier_in = 1'b1;
    cyc(3);
    expect_out("R7 false start", 1'b1, 2'b10);
    cyc(5);
    expect_out("R7 false hold", 1'b1, 2'b10);
    carrier_in = 1'b0;
    cyc(2);
    expect_out("R7 false tail", 1'b1, 2'b10);
    cyc(1);
    expect_out("R7 false end", 1'b0, 2'b00);
    false_car = 1'b0;
    cyc(3);
    carrier_in = 1'b1;
    cyc(3);
    cyc(1); expect_out("R7 byte kept s0", 1'b1, 2'b10);
    cyc(1); expect_out("R7 byte kept s1", 1'b1, 2'b10);
    cyc(1); expect_out("R7 byte kept s2", 1'b1, 2'b01);
    cyc(1); expect_out("R7 byte kept s3", 1'b1, 2'b01);
    cyc(1); expect_out("R8 underflow", 1'b0, 2'b00);
    end_carrier();
  endtask

  task automatic test_slow();
    slow_mode = 1'b1;
    push(8'hE4);
    carrier_in = 1'b1;
    cyc(3);
    expect_out("R2 slow rise", 1'b1, 2'b00);
    cyc(1);  expect_out("R4 s0 first", 1'b1, 2'b00);
    cyc(9);  expect_out("R4 s0 last", 1'b1, 2'b00);
    cyc(1);  expect_out("R4 s1 first", 1'b1, 2'b01);
    cyc(9);  expect_out("R4 s1 last", 1'b1, 2'b01);
    cyc(1);  expect_out("R4 s2 first", 1'b1, 2'b10);
    cyc(10); expect_out("R4 s3 first", 1'b1, 2'b11);
    cyc(9);  expect_out("R4 s3 last", 1'b1, 2'b11);
    cyc(1);  expect_out("R4 R8 slow underflow", 1'b0, 2'b00);
    end_carrier();
    slow_mode = 1'b0;
  endtask

  task automatic test_backpressure();
    logic [7:0] vals [8];
    for (int i = 0; i < 8; i++) begin
      vals[i] = 8'(i * 37 + 5);
      check("R9 ready before fill", int'(in_ready), 1);
      push(vals[i]);
    end
    check("R9 full ready", int'(in_ready), 0);
    push(8'hFF);
    carrier_in = 1'b1;
    cyc(3);
    for (int i = 0; i < 32; i++) begin
      cyc(1);
      expect_out($sformatf("R9 R3 stream sym %0d", i), 1'b1,
                 vals[i / 4][2 * (i % 4) +: 2]);
    end
    cyc(1);
    expect_out("R9 extra byte dropped", 1'b0, 2'b00);
    end_carrier();
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    test_reset();
    test_fast_underflow();
    test_toggle();
    test_false();
    test_slow();
    test_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule